// File: doc/BRIEF.md
# NMI Context Save and Cause Unit

This block keeps the processor context needed to return from a non-maskable interrupt, together with a record of why the most recent interrupt or exception was taken. When the core accepts an NMI, it strobes the block with the return PC, the current program status word and an NMI cause code. The block stores the PC and PSW in two dedicated save registers and writes the NMI code into the upper half of a split cause register. A maskable interrupt or exception is reported on a separate strobe, and its code goes into the lower half of that register.

On a return-from-interrupt, the block presents the saved PC and PSW to the core as restore values. A small system-register port gives the core combinational read access to all three registers. It also lets the core write the two save registers. The cause register cannot be written through this port.

Top module: `nmi_ctx_unit`

## Requirements
- R1: One clock edge after `nmi_take_i` is high, the PC save register holds the chosen return PC and the PSW save register holds `nmi_psw_i`. Both are subject to the masks in R2 and R3.
- R2: Bits 31 to 26 of the PC save register always read as zero, whether the value came from a capture or from a port write.
- R3: Bits 31 to 8 of the PSW save register always read as zero, whether the value came from a capture or from a port write.
- R4: While `reti_i` is high, `restore_valid_o` is high in the same cycle and `restore_pc_o`/`restore_psw_o` equal the save register contents. While `reti_i` is low, `restore_valid_o` is low.
- R5: An NMI accept loads `nmi_code_i` into cause bits 31:16 and leaves bits 15:0 unchanged.
- R6: An exception or maskable-interrupt accept loads `exc_code_i` into cause bits 15:0 and leaves bits 31:16 unchanged.
- R7: When both accepts occur in the same cycle, both halves of the cause register update. Only the NMI save registers are loaded.
- R8: A port write with `sr_idx_i` = 2 does not change the cause register.
- R9: While `rst_ni` is low, the cause register is cleared to zero asynchronously. The save registers are not reset.
- R10: A port write with `sr_idx_i` = 0 loads the PC save register, and one with `sr_idx_i` = 1 loads the PSW save register. In both cases the fixed-zero bits are masked. If an NMI accept occurs in the same cycle, the capture wins and the write is dropped.
- R11: `sr_rdata_o` is combinational from `sr_idx_i`: 0 selects the PC save register, 1 the PSW save register, 2 the cause register, and 3 reads as zero.
- R12: The captured PC is `nmi_alt_pc_i` when `nmi_use_alt_i` is high (the interrupted-divide case). Otherwise it is `nmi_next_pc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_take_i | input | 1 | NMI accept strobe |
| nmi_next_pc_i | input | 32 | Address of the instruction after the current one |
| nmi_alt_pc_i | input | 32 | Alternate return address for an interrupted divide |
| nmi_use_alt_i | input | 1 | Selects the alternate return address |
| nmi_psw_i | input | 32 | Current PSW at NMI accept |
| nmi_code_i | input | 16 | NMI cause code |
| exc_take_i | input | 1 | Exception or maskable interrupt accept strobe |
| exc_code_i | input | 16 | Exception or maskable interrupt cause code |
| reti_i | input | 1 | Return-from-interrupt strobe |
| restore_valid_o | output | 1 | Restore values valid (follows reti_i) |
| restore_pc_o | output | 32 | PC value to restore |
| restore_psw_o | output | 32 | PSW value to restore |
| sr_idx_i | input | 2 | System-register index |
| sr_we_i | input | 1 | System-register write enable |
| sr_wdata_i | input | 32 | System-register write data |
| sr_rdata_o | output | 32 | System-register read data |

## Verification
The assertions check the following properties on every cycle:
- the fixed-zero bits of both save registers;
- `restore_valid_o` tracking `reti_i`;
- the PC and PSW captured on an NMI, including the alternate-address select;
- the untouched half of the cause register on a single accept;
- the cause register staying stable when it is the write target.

The bench sweeps every combination of the NMI, exception, write, alternate-select and index controls against an arithmetic model. Only these scenarios show the following:
- the capture-over-write precedence;
- reads at each index;
- the restore values during a return;
- the reset value of the cause register.

// File: rtl/nmi_ctx_pkg.sv
`timescale 1ns/1ps
package nmi_ctx_pkg;
  localparam int XLEN     = 32;
  localparam int PC_KEEP  = 26;
  localparam int PSW_KEEP = 8;
  localparam int CODE_W   = 16;

  typedef enum logic [1:0] {
    SR_NPC   = 2'd0,
    SR_NPSW  = 2'd1,
    SR_CAUSE = 2'd2,
    SR_NONE  = 2'd3
  } sr_idx_e;
endpackage

// File: rtl/nmi_save_reg.sv
`timescale 1ns/1ps
// Save register with hardwired-zero upper bits; no reset by intent.
module nmi_save_reg #(
  parameter int W    = 32,
  parameter int KEEP = 26
) (
  input  logic         clk_i,
  input  logic         cap_i,
  input  logic [W-1:0] cap_d_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_d_i,
  output logic [W-1:0] q_o
);
  logic [KEEP-1:0] q;

  always_ff @(posedge clk_i) begin
    if (cap_i)     q <= cap_d_i[KEEP-1:0];
    else if (wr_i) q <= wr_d_i[KEEP-1:0];
  end

  generate
    if (KEEP < W) begin : g_pad
      assign q_o = {{(W-KEEP){1'b0}}, q};
    end else begin : g_full
      assign q_o = q;
    end
  endgenerate
endmodule

// File: rtl/nmi_cause_reg.sv
`timescale 1ns/1ps
// Split cause register: half 1 = NMI code, half 0 = exception code.
module nmi_cause_reg #(
  parameter int HALF = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        we_i,
  input  logic [2*HALF-1:0] d_i,
  output logic [2*HALF-1:0] q_o
);
  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q <= '0;
        else if (we_i[h]) q <= d_i[h*HALF +: HALF];
      end
      assign q_o[h*HALF +: HALF] = q;
    end
  endgenerate
endmodule

// File: rtl/nmi_sr_rmux.sv
`timescale 1ns/1ps
module nmi_sr_rmux
  import nmi_ctx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   idx_i,
  input  logic [W-1:0] npc_i,
  input  logic [W-1:0] npsw_i,
  input  logic [W-1:0] cause_i,
  output logic [W-1:0] rdata_o
);
  always_comb begin
    unique case (sr_idx_e'(idx_i))
      SR_NPC:   rdata_o = npc_i;
      SR_NPSW:  rdata_o = npsw_i;
      SR_CAUSE: rdata_o = cause_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/nmi_ctx_unit.sv
`timescale 1ns/1ps
module nmi_ctx_unit
  import nmi_ctx_pkg::*;
#(
  parameter int W        = XLEN,
  parameter int PCK      = PC_KEEP,
  parameter int PSWK     = PSW_KEEP,
  parameter int CW       = CODE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         nmi_take_i,
  input  logic [W-1:0] nmi_next_pc_i,
  input  logic [W-1:0] nmi_alt_pc_i,
  input  logic         nmi_use_alt_i,
  input  logic [W-1:0] nmi_psw_i,
  input  logic [CW-1:0] nmi_code_i,
  input  logic         exc_take_i,
  input  logic [CW-1:0] exc_code_i,
  input  logic         reti_i,
  output logic         restore_valid_o,
  output logic [W-1:0] restore_pc_o,
  output logic [W-1:0] restore_psw_o,
  input  logic [1:0]   sr_idx_i,
  input  logic         sr_we_i,
  input  logic [W-1:0] sr_wdata_i,
  output logic [W-1:0] sr_rdata_o
);
  logic [W-1:0]    ret_pc;
  logic [W-1:0]    npc_q, npsw_q;
  logic [2*CW-1:0] cause_q;
  logic            wr_npc, wr_npsw;

  assign ret_pc  = nmi_use_alt_i ? nmi_alt_pc_i : nmi_next_pc_i;
  // capture has precedence over a same-cycle port write
  assign wr_npc  = sr_we_i && (sr_idx_e'(sr_idx_i) == SR_NPC)  && !nmi_take_i;
  assign wr_npsw = sr_we_i && (sr_idx_e'(sr_idx_i) == SR_NPSW) && !nmi_take_i;

  nmi_save_reg #(.W(W), .KEEP(PCK)) u_npc (
    .clk_i   (clk_i),
    .cap_i   (nmi_take_i),
    .cap_d_i (ret_pc),
    .wr_i    (wr_npc),
    .wr_d_i  (sr_wdata_i),
    .q_o     (npc_q)
  );

  nmi_save_reg #(.W(W), .KEEP(PSWK)) u_npsw (
    .clk_i   (clk_i),
    .cap_i   (nmi_take_i),
    .cap_d_i (nmi_psw_i),
    .wr_i    (wr_npsw),
    .wr_d_i  (sr_wdata_i),
    .q_o     (npsw_q)
  );

  nmi_cause_reg #(.HALF(CW)) u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   ({nmi_take_i, exc_take_i}),
    .d_i    ({nmi_code_i, exc_code_i}),
    .q_o    (cause_q)
  );

  nmi_sr_rmux #(.W(W)) u_rmux (
    .idx_i   (sr_idx_i),
    .npc_i   (npc_q),
    .npsw_i  (npsw_q),
    .cause_i (cause_q),
    .rdata_o (sr_rdata_o)
  );

  assign restore_valid_o = reti_i;
  assign restore_pc_o    = npc_q;
  assign restore_psw_o   = npsw_q;
endmodule

// File: rtl/nmi_ctx_chk.sv
`timescale 1ns/1ps
module nmi_ctx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        nmi_take_i,
  input logic        exc_take_i,
  input logic        nmi_use_alt_i,
  input logic [31:0] nmi_next_pc_i,
  input logic [31:0] nmi_alt_pc_i,
  input logic [31:0] nmi_psw_i,
  input logic [1:0]  sr_idx_i,
  input logic        sr_we_i,
  input logic        reti_i,
  input logic        restore_valid_o,
  input logic [31:0] restore_pc_o,
  input logic [31:0] restore_psw_o,
  input logic [31:0] cause_q
);
  // R2
  pc_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_pc_o[31:26] == 6'd0);
  // R3
  psw_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_psw_o[31:8] == 24'd0);
  // R4
  reti_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_valid_o == reti_i);
  // R1
  psw_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_take_i |=> restore_psw_o[7:0] == $past(nmi_psw_i[7:0]));
  // R12
  pc_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_take_i |=> restore_pc_o[25:0] ==
      ($past(nmi_use_alt_i) ? $past(nmi_alt_pc_i[25:0]) : $past(nmi_next_pc_i[25:0])));
  // R5
  nmi_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_take_i && !exc_take_i) |=> $stable(cause_q[15:0]));
  // R6
  exc_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_take_i && !nmi_take_i) |=> $stable(cause_q[31:16]));
  // R8
  cause_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_we_i && sr_idx_i == 2'd2 && !nmi_take_i && !exc_take_i) |=> $stable(cause_q));
endmodule

bind nmi_ctx_unit nmi_ctx_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .nmi_take_i      (nmi_take_i),
  .exc_take_i      (exc_take_i),
  .nmi_use_alt_i   (nmi_use_alt_i),
  .nmi_next_pc_i   (nmi_next_pc_i),
  .nmi_alt_pc_i    (nmi_alt_pc_i),
  .nmi_psw_i       (nmi_psw_i),
  .sr_idx_i        (sr_idx_i),
  .sr_we_i         (sr_we_i),
  .reti_i          (reti_i),
  .restore_valid_o (restore_valid_o),
  .restore_pc_o    (restore_pc_o),
  .restore_psw_o   (restore_psw_o),
  .cause_q         (cause_q)
);

// File: tb/nmi_ctx_unit_tb_top.sv
`timescale 1ns/1ps
module nmi_ctx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_take = 1'b0, exc_take = 1'b0, use_alt = 1'b0, reti = 1'b0, we = 1'b0;
  logic [31:0] next_pc = '0, alt_pc = '0, psw = '0, wdata = '0;
  logic [15:0] ncode = '0, ecode = '0;
  logic [1:0]  idx = '0;
  logic        rvalid;
  logic [31:0] rpc, rpsw, rdata;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_pc, m_psw, m_cause;

  localparam logic [31:0] PC_MASK  = 32'h03FF_FFFF;
  localparam logic [31:0] PSW_MASK = 32'h0000_00FF;

  always #2 clk = ~clk;

  nmi_ctx_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .nmi_take_i(nmi_take), .nmi_next_pc_i(next_pc), .nmi_alt_pc_i(alt_pc),
    .nmi_use_alt_i(use_alt), .nmi_psw_i(psw), .nmi_code_i(ncode),
    .exc_take_i(exc_take), .exc_code_i(ecode), .reti_i(reti),
    .restore_valid_o(rvalid), .restore_pc_o(rpc), .restore_psw_o(rpsw),
    .sr_idx_i(idx), .sr_we_i(we), .sr_wdata_i(wdata), .sr_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic n, input logic e, input logic w, input logic a,
                      input logic [1:0] wi, input logic [31:0] seed);
    @(negedge clk);
    nmi_take = n; exc_take = e; we = w; use_alt = a; idx = wi;
    next_pc = seed ^ 32'hFC00_1234;
    alt_pc  = ~seed;
    psw     = seed * 32'd7 + 32'hFFFF_FF00;
    wdata   = seed ^ 32'hFFFF_FFFF ^ {seed[15:0], seed[31:16]};
    ncode   = seed[31:16] ^ 16'hA5A5;
    ecode   = seed[15:0] + 16'd3;
    @(posedge clk);
    if (n) begin
      m_pc  = (a ? alt_pc : next_pc) & PC_MASK;
      m_psw = psw & PSW_MASK;
      m_cause[31:16] = ncode;
    end else if (w) begin
      if (wi == 2'd0) m_pc  = wdata & PC_MASK;
      if (wi == 2'd1) m_psw = wdata & PSW_MASK;
    end
    if (e) m_cause[15:0] = ecode;
    @(negedge clk);
    nmi_take = 0; exc_take = 0; we = 0;
  endtask

  task automatic read_all();
    idx = 2'd0; #1 chk("R1 R2 R10 R12 pc save", rdata, m_pc);
    idx = 2'd1; #1 chk("R1 R3 R10 psw save", rdata, m_psw);
    idx = 2'd2; #1 chk("R5 R6 R7 R8 cause", rdata, m_cause);
    idx = 2'd3; #1 chk("R11 unused index", rdata, 32'd0);
    reti = 1'b1;
    #1 chk("R4 restore valid", {31'd0, rvalid}, 32'd1);
    chk("R4 restore pc", rpc, m_pc);
    chk("R4 restore psw", rpsw, m_psw);
    reti = 1'b0;
    #1 chk("R4 valid low", {31'd0, rvalid}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_cause = '0;
    repeat (3) @(posedge clk);
    idx = 2'd2; #1 chk("R9 cause reset", rdata, 32'd0);
    idx = 2'd3; #1 chk("R11 index 3 zero", rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // establish defined save contents
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'hFFFF_FFFF);
    read_all();
    // exhaustive control sweep: nmi, exc, we, alt, write index
    for (int i = 0; i < 64; i++) begin
      step(i[0], i[1], i[2], i[3], i[5:4], 32'h9E37_79B9 * (i + 1));
      read_all();
    end
    // reset clears cause again, save regs keep contents
    @(negedge clk); rst_n = 1'b0;
    #1 idx = 2'd2; #1 chk("R9 cause async clear", rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule